// File: doc/BRIEF.md
# Condition Code Flag Unit

This block keeps an 8-bit condition code register and rewrites its arithmetic flags (negative N, zero Z, overflow V, carry C) from the operands and result of the operation the datapath has just performed. The flags come from the sign bits of operand a, operand b and result r, not from a carry chain. That lets the unit sit beside an ALU and use only the values the ALU already produces. A size select picks between byte (8-bit) and word (16-bit) evaluation.

Besides the arithmetic updates, the register can be loaded whole, or a single bit can be written. Single-bit writes are used for the control flags: half-carry H, interrupt mask I, the second interrupt mask X and the stop-disable bit S. An operation takes effect at the clock edge where it is presented, and the new register value is visible on `ccr_o` from that edge on. The block has no state machine: its only state is the register.

Top module: `ccu_flag_unit`

## Requirements
- R1: While `rst_n` is low the register reads 0xD0, which sets S, X and I and clears all other bits.
- R2: Operation code 0 (hold) and operation code 7 (unused) leave the register unchanged.
- R3: Operation code 1 (add) sets C to the top bit of (a&b)|(b&~r)|(a&~r) and V to the top bit of (a&b&~r)|(~a&~b&r).
- R4: Operation code 2 (subtract) sets C to the top bit of (~a&b)|(b&r)|(~a&r) and V to the top bit of (a&~b&~r)|(~a&b&r).
- R5: Operation codes 1 to 4 set N (bit 3) to the top bit of r and set Z (bit 2) exactly when r is zero. C is bit 0 and V is bit 1. The top bit is bit 7 when `wide_i`=0 and bit 15 when `wide_i`=1.
- R6: Operation code 3 (test) clears V and leaves C unchanged.
- R7: Operation code 4 (shift) sets C to `shift_c_i` and sets V to the new N xor the new C.
- R8: Operation code 5 (load) copies `load_val_i` into all eight bits.
- R9: Operation code 6 (bit write) sets bit `bit_sel_i` to `bit_val_i` and leaves the other seven bits unchanged.
- R10: Operation codes 1 to 4 leave I (bit 4), H (bit 5), X (bit 6) and S (bit 7) unchanged.
- R11: When `wide_i`=0, bits 15..8 of a, b and r have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (0 hold, 1 add, 2 sub, 3 test, 4 shift, 5 load, 6 bit write, 7 unused) |
| wide_i | input | 1 | Size select: 0 byte, 1 word |
| a_i | input | 16 | Operand a |
| b_i | input | 16 | Operand b |
| r_i | input | 16 | Result of the operation |
| shift_c_i | input | 1 | Carry produced by a shift |
| load_val_i | input | 8 | Value for a whole-register load |
| bit_sel_i | input | 3 | Bit index for a single-bit write |
| bit_val_i | input | 1 | Value for a single-bit write |
| ccr_o | output | 8 | Condition code register |

## Verification
The assertions assume that every input is at a known value at each rising edge after reset. They also assume that an operation code applies for exactly one cycle. The C and V rules are checked only against their sign-bit definitions, so no particular relation between r and a, b is needed there. The stimulus drives every input from the falling edge, so inputs are always defined. For add and subtract it supplies a result that really is the sum or the difference, which lets the reference model get carry and overflow from integer arithmetic. In byte mode it fills the upper operand bits with unrelated values.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    localparam int CCR_W = 8;
    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_I = 4;
    localparam int POS_H = 5;
    localparam int POS_X = 6;
    localparam int POS_S = 7;
    localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_TEST  = 3'd3,
        OP_SHIFT = 3'd4,
        OP_LOAD  = 3'd5,
        OP_BITWR = 3'd6,
        OP_SPARE = 3'd7
    } ccu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic add_v;
        logic add_c;
        logic sub_v;
        logic sub_c;
    } ccu_arith_t;
endpackage

// File: rtl/ccu_arith_flags.sv
module ccu_arith_flags
    import ccu_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              wide_i,
    input  logic [WIDE_W-1:0] a_i,
    input  logic [WIDE_W-1:0] b_i,
    input  logic [WIDE_W-1:0] r_i,
    output ccu_arith_t        flags_o
);
    localparam int NUM_SIZES = 2;

    ccu_arith_t per_size [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int SW = (g == 0) ? NARROW_W : WIDE_W;
        logic [SW-1:0] a_s, b_s, r_s;
        assign a_s = a_i[SW-1:0];
        assign b_s = b_i[SW-1:0];
        assign r_s = r_i[SW-1:0];
        logic [SW-1:0] add_c_vec, add_v_vec, sub_c_vec, sub_v_vec;
        assign add_c_vec = (a_s & b_s) | (b_s & ~r_s) | (a_s & ~r_s);
        assign add_v_vec = (a_s & b_s & ~r_s) | (~a_s & ~b_s & r_s);
        assign sub_c_vec = (~a_s & b_s) | (b_s & r_s) | (~a_s & r_s);
        assign sub_v_vec = (a_s & ~b_s & ~r_s) | (~a_s & b_s & r_s);
        assign per_size[g].n     = r_s[SW-1];
        assign per_size[g].z     = ~|r_s;
        assign per_size[g].add_c = add_c_vec[SW-1];
        assign per_size[g].add_v = add_v_vec[SW-1];
        assign per_size[g].sub_c = sub_c_vec[SW-1];
        assign per_size[g].sub_v = sub_v_vec[SW-1];
    end

    assign flags_o = wide_i ? per_size[1] : per_size[0];
endmodule

// File: rtl/ccu_next_value.sv
module ccu_next_value
    import ccu_pkg::*;
(
    input  ccu_op_e          op_i,
    input  ccu_arith_t       flags_i,
    input  logic             shift_c_i,
    input  logic [CCR_W-1:0] load_val_i,
    input  logic [2:0]       bit_sel_i,
    input  logic             bit_val_i,
    input  logic [CCR_W-1:0] cur_i,
    output logic [CCR_W-1:0] next_o
);
    always_comb begin
        next_o = cur_i;
        unique case (op_i)
            OP_ADD: begin
                next_o[POS_C] = flags_i.add_c;
                next_o[POS_V] = flags_i.add_v;
                next_o[POS_Z] = flags_i.z;
                next_o[POS_N] = flags_i.n;
            end
            OP_SUB: begin
                next_o[POS_C] = flags_i.sub_c;
                next_o[POS_V] = flags_i.sub_v;
                next_o[POS_Z] = flags_i.z;
                next_o[POS_N] = flags_i.n;
            end
            OP_TEST: begin
                next_o[POS_V] = 1'b0;
                next_o[POS_Z] = flags_i.z;
                next_o[POS_N] = flags_i.n;
            end
            OP_SHIFT: begin
                next_o[POS_C] = shift_c_i;
                next_o[POS_V] = flags_i.n ^ shift_c_i;
                next_o[POS_Z] = flags_i.z;
                next_o[POS_N] = flags_i.n;
            end
            OP_LOAD:  next_o = load_val_i;
            OP_BITWR: next_o[bit_sel_i] = bit_val_i;
            OP_HOLD, OP_SPARE: next_o = cur_i;
            default:  next_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ccu_flag_unit.sv
module ccu_flag_unit
    import ccu_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic [WIDE_W-1:0] a_i,
    input  logic [WIDE_W-1:0] b_i,
    input  logic [WIDE_W-1:0] r_i,
    input  logic              shift_c_i,
    input  logic [CCR_W-1:0]  load_val_i,
    input  logic [2:0]        bit_sel_i,
    input  logic              bit_val_i,
    output logic [CCR_W-1:0]  ccr_o
);
    ccu_op_e          op_cur;
    ccu_arith_t       arith;
    logic [CCR_W-1:0] ccr_q, ccr_d;

    assign op_cur = ccu_op_e'(op_i);

    ccu_arith_flags #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) arith_i (
        .wide_i (wide_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .r_i    (r_i),
        .flags_o(arith)
    );

    ccu_next_value next_i (
        .op_i      (op_cur),
        .flags_i   (arith),
        .shift_c_i (shift_c_i),
        .load_val_i(load_val_i),
        .bit_sel_i (bit_sel_i),
        .bit_val_i (bit_val_i),
        .cur_i     (ccr_q),
        .next_o    (ccr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ccr_q <= CCR_RESET;
        else        ccr_q <= ccr_d;
    end

    assign ccr_o = ccr_q;

    logic arith_op;
    assign arith_op = (op_i == 3'd1) || (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd4);

    a_r2_hold_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd0) || (op_i == 3'd7)) |=> $stable(ccr_o));

    a_r6_test_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> (ccr_o[POS_C] == $past(ccr_o[POS_C])) && !ccr_o[POS_V]);

    a_r7_shift_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> (ccr_o[POS_V] == (ccr_o[POS_N] ^ ccr_o[POS_C]))
                        && (ccr_o[POS_C] == $past(shift_c_i)));

    a_r8_load_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> ccr_o == $past(load_val_i));

    a_r9_bitwrite_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6) |=> $countones(ccr_o ^ $past(ccr_o)) <= 1);

    a_r10_control_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        arith_op |=> $stable(ccr_o[CCR_W-1:POS_I]));

    a_r5_zero_negative_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        arith_op |=> !(ccr_o[POS_Z] && ccr_o[POS_N]));
endmodule

// File: tb/ccu_flag_unit_tb_top.sv
module ccu_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_i;
    logic        wide_i;
    logic [15:0] a_i, b_i, r_i;
    logic        shift_c_i;
    logic [7:0]  load_val_i;
    logic [2:0]  bit_sel_i;
    logic        bit_val_i;
    logic [7:0]  ccr_o;

    int checks = 0;
    int errors = 0;
    int model;
    string tag;

    always #5 clk = ~clk;

    ccu_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i),
        .a_i(a_i), .b_i(b_i), .r_i(r_i), .shift_c_i(shift_c_i),
        .load_val_i(load_val_i), .bit_sel_i(bit_sel_i), .bit_val_i(bit_val_i),
        .ccr_o(ccr_o)
    );

    task automatic compare();
        checks++;
        if (ccr_o !== model[7:0]) begin
            errors++;
            $display("FAIL %s: ccr actual %02h expected %02h", tag, ccr_o, model[7:0]);
        end
    endtask

    // Behavioural reference: flags from integer arithmetic on the operand values.
    task automatic apply(input int op, input bit wide, input int a, input int b,
                         input int rr, input bit sc, input int lv, input int sel, input bit bv);
        int w, mask, av, bv2, rv, sgn, sum;
        bit n, z, c, v;
        w = wide ? 16 : 8;
        mask = (1 << w) - 1;
        sgn = 1 << (w - 1);
        av = a & mask; bv2 = b & mask;
        rv = rr & mask;
        if (op == 1) rv = (av + bv2) & mask;
        if (op == 2) rv = (av - bv2) & mask;
        op_i = op[2:0]; wide_i = wide;
        // R11: upper bits filled with noise in byte mode
        a_i = wide ? a[15:0] : {8'($urandom), a[7:0]};
        b_i = wide ? b[15:0] : {8'($urandom), b[7:0]};
        r_i = wide ? rv[15:0] : {8'($urandom), rv[7:0]};
        shift_c_i = sc; load_val_i = lv[7:0]; bit_sel_i = sel[2:0]; bit_val_i = bv;
        n = (rv & sgn) != 0;
        z = (rv == 0);
        c = model[0]; v = model[1];
        case (op)
            1: begin // R3
                sum = av + bv2;
                c = (sum >> w) & 1;
                v = (((av & sgn) == (bv2 & sgn)) && ((rv & sgn) != (av & sgn)));
                tag = "R3/R5/R10/R11";
            end
            2: begin // R4
                c = (av < bv2);
                v = (((av & sgn) != (bv2 & sgn)) && ((rv & sgn) != (av & sgn)));
                tag = "R4/R5/R10/R11";
            end
            3: begin v = 0; tag = "R6/R5/R10"; end
            4: begin c = sc; v = n ^ sc; tag = "R7/R5/R10"; end
            default: ;
        endcase
        if (op >= 1 && op <= 4) begin
            model[0] = c; model[1] = v; model[2] = z; model[3] = n;
        end else if (op == 5) begin
            model = lv & 8'hFF; tag = "R8";
        end else if (op == 6) begin
            if (bv) model = model | (1 << sel);
            else    model = model & ~(1 << sel);
            tag = "R9";
        end else begin
            tag = "R2";
        end
    endtask

    task automatic step(input int op, input bit wide, input int a, input int b,
                        input int rr, input bit sc, input int lv, input int sel, input bit bv);
        apply(op, wide, a, b, rr, sc, lv, sel, bv);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        op_i = 3'd5; wide_i = 0; a_i = 0; b_i = 0; r_i = 0;
        shift_c_i = 0; load_val_i = 8'h00; bit_sel_i = 0; bit_val_i = 0;
        repeat (3) @(negedge clk);
        model = 8'hD0; tag = "R1";
        compare(); // R1 reset value, load presented during reset is ignored
        op_i = 3'd0;
        @(negedge clk);
        rst_n = 1'b1;
        // R2 hold and unused code
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(7, 1, 1, 2, 3, 1, 8'hFF, 1, 1);
        // R8 load
        step(5, 0, 0, 0, 0, 0, 8'h00, 0, 0);
        // R3 byte: 0x7F+0x01 -> N=1,V=1,C=0
        step(1, 0, 8'h7F, 8'h01, 0, 0, 0, 0, 0);
        // R3 byte: 0xFF+0x01 -> Z=1,C=1
        step(1, 0, 8'hFF, 8'h01, 0, 0, 0, 0, 0);
        // R3 word: 0x8000+0x8000 -> C=1,V=1,Z=1
        step(1, 1, 16'h8000, 16'h8000, 0, 0, 0, 0, 0);
        // R4 word: 0x8000-0x0001 -> V=1
        step(2, 1, 16'h8000, 16'h0001, 0, 0, 0, 0, 0);
        // R4 byte: 0x00-0x01 -> C=1,N=1
        step(2, 0, 8'h00, 8'h01, 0, 0, 0, 0, 0);
        // R6 test keeps C=1, clears V
        step(3, 1, 0, 0, 16'h0000, 0, 0, 0, 0);
        // R7 shift: N=1, carry 1 -> V=0
        step(4, 0, 0, 0, 8'h80, 1, 0, 0, 0);
        step(4, 1, 0, 0, 16'h0001, 1, 0, 0, 0);
        // R9 bit writes on control flags
        step(6, 0, 0, 0, 0, 0, 0, 5, 1);
        step(6, 0, 0, 0, 0, 0, 0, 7, 0);
        step(6, 0, 0, 0, 0, 0, 0, 0, 1);
        // R8 load then R10 arithmetic keeps top bits
        step(5, 0, 0, 0, 0, 0, 8'hF0, 0, 0);
        step(1, 0, 8'h40, 8'h40, 0, 0, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
                 int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF),
                 int'($urandom & 16'hFFFF), bit'($urandom_range(0, 1)),
                 int'($urandom & 8'hFF), int'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 1)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule